// File: doc/BRIEF.md
# Packed-Byte SAD Accumulator

This block measures how well two 8x8 pixel blocks match by summing the absolute differences of the pixels at the same positions. Motion estimation uses it to score candidate displacements. A producer streams both blocks as 32-bit words. Each word carries four unsigned 8-bit pixels, and the producer presents one word of the current block and the matching word of the reference block together. The producer walks the rows in order, two words per row. Addressing and stride stepping stay with the producer.

Each accepted word pair is handled in one cycle. A saturating unsigned subtraction runs in both directions in every byte lane. The two results are ORed, and because one of them is always zero this gives the absolute difference. Neighbouring byte lanes are then added into packed 16-bit half-words, and the half-words are added into a partial sum that joins the running total. A `start` pulse opens a block. After sixteen accepted pairs, `done` pulses once and the total holds until the next `start`.

Top module: `pkbyte_sad`

## Requirements
- R1: After reset, `sad_sum` is 0 and `done` is 0.
- R2: A cycle with `start` high clears `sad_sum` to 0 at the next edge and opens a block. A word pair offered in that same cycle is not accepted.
- R3: Each accepted pair adds the sum over the four byte lanes of |cur - ref| to `sad_sum`. Lane i occupies bits [8i+7:8i] of each word, and all pixels are unsigned.
- R4: A lane where cur < ref contributes ref - cur, not a wrapped value. cur=0 with ref=255 adds 255, and so does cur=255 with ref=0.
- R5: A cycle with `in_valid` low leaves `sad_sum` unchanged.
- R6: `done` is high for exactly one cycle. It rises at the edge that accepts the 16th valid pair after `start`, and `sad_sum` is already final in that cycle.
- R7: After `done`, `sad_sum` holds and offered word pairs are ignored until the next `start`.
- R8: Word pairs offered after reset and before the first `start` are ignored.
- R9: The largest block total, 64 x 255 = 16320, is reported exactly, with no wrap.
- R10: A `start` in the middle of a block discards the partial total, and a full 16 pairs are then needed before `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a new block and clears the total |
| in_valid | input | 1 | Qualifies the word pair |
| cur_word | input | 32 | Four packed current-block pixels |
| ref_word | input | 32 | Four packed reference-block pixels |
| done | output | 1 | One-cycle pulse when the block is complete |
| sad_sum | output | 14 | Running, then final, sum of absolute differences |

## Verification
The bench stresses lanes where the reference exceeds the current pixel, including 0 against 255. A design that wraps instead of saturating, or that subtracts in only one direction, reports totals far too large or too small. An all-extreme block checks 16320, which catches an accumulator one bit too narrow. The bench also offers words before the first start, in the start cycle, after done and during gaps with `in_valid` low, and restarts a block halfway through. An off-by-one word counter, a late or stretched `done`, or a total that keeps moving after completion each produce a miscompare against the cycle model.

// File: rtl/sad_pkg.sv
package sad_pkg;
    localparam int PIX_W = 8;

    typedef logic [PIX_W-1:0]   pix_t;
    typedef logic [2*PIX_W-1:0] half_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } blk_state_e;

    // unsigned subtraction clamped at zero
    function automatic pix_t sat_sub(input pix_t a, input pix_t b);
        return (a > b) ? pix_t'(a - b) : '0;
    endfunction
endpackage

// File: rtl/sad_lane.sv
module sad_lane
    import sad_pkg::*;
(
    input  pix_t a_pix,
    input  pix_t b_pix,
    output pix_t abs_diff
);
    pix_t up_d, dn_d;

    always_comb begin
        up_d     = sat_sub(a_pix, b_pix);
        dn_d     = sat_sub(b_pix, a_pix);
        abs_diff = up_d | dn_d;   // one side is always zero
    end
endmodule

// File: rtl/sad_fold.sv
module sad_fold
    import sad_pkg::*;
#(
    parameter int LANES = 4,
    parameter int SUM_W = PIX_W + $clog2(LANES)
) (
    input  logic [LANES*PIX_W-1:0] diffs,
    output logic [SUM_W-1:0]       partial
);
    localparam int PAIRS = LANES / 2;

    half_t halves [PAIRS];

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        // widen a lane pair into one packed half-word
        assign halves[p] = half_t'(diffs[(2*p)*PIX_W +: PIX_W])
                         + half_t'(diffs[(2*p+1)*PIX_W +: PIX_W]);
    end

    always_comb begin
        partial = '0;
        for (int p = 0; p < PAIRS; p++) begin
            partial = partial + SUM_W'(halves[p]);
        end
    end
endmodule

// File: rtl/sad_ctrl.sv
module sad_ctrl
    import sad_pkg::*;
#(
    parameter int BLOCK_WORDS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic in_valid,
    output logic accept,
    output logic done
);
    localparam int CNT_W = $clog2(BLOCK_WORDS);

    blk_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             last;

    always_comb begin
        accept = (state == ST_RUN) && in_valid && !start;
        last   = accept && (cnt == CNT_W'(BLOCK_WORDS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= last;
            if (start) begin
                state <= ST_RUN;
                cnt   <= '0;
            end else if (last) begin
                state <= ST_IDLE;
                cnt   <= '0;
            end else if (accept) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pkbyte_sad.sv
module pkbyte_sad
    import sad_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int BLOCK_WORDS = 16
) (
    input  logic                                            clk,
    input  logic                                            rst,
    input  logic                                            start,
    input  logic                                            in_valid,
    input  logic [LANES*PIX_W-1:0]                          cur_word,
    input  logic [LANES*PIX_W-1:0]                          ref_word,
    output logic                                            done,
    output logic [PIX_W+$clog2(LANES*BLOCK_WORDS)-1:0]      sad_sum
);
    localparam int SUM_W = PIX_W + $clog2(LANES);
    localparam int ACC_W = PIX_W + $clog2(LANES * BLOCK_WORDS);

    logic [LANES*PIX_W-1:0] diffs;
    logic [SUM_W-1:0]       partial;
    logic                   accept;
    logic [ACC_W-1:0]       acc;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        sad_lane u_lane (
            .a_pix    (cur_word[i*PIX_W +: PIX_W]),
            .b_pix    (ref_word[i*PIX_W +: PIX_W]),
            .abs_diff (diffs[i*PIX_W +: PIX_W])
        );
    end

    sad_fold #(.LANES(LANES), .SUM_W(SUM_W)) u_fold (
        .diffs   (diffs),
        .partial (partial)
    );

    sad_ctrl #(.BLOCK_WORDS(BLOCK_WORDS)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .in_valid (in_valid),
        .accept   (accept),
        .done     (done)
    );

    always_ff @(posedge clk) begin
        if (rst || start) begin
            acc <= '0;
        end else if (accept) begin
            acc <= acc + ACC_W'(partial);
        end
    end

    assign sad_sum = acc;
endmodule

// File: rtl/sad_chk.sv
module sad_chk #(
    parameter int LANES       = 4,
    parameter int BLOCK_WORDS = 16,
    parameter int ACC_W       = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             in_valid,
    input logic             done,
    input logic [ACC_W-1:0] sad_sum
);
    localparam int MAX_STEP = LANES * 255;

    logic open_blk;
    logic finished;
    int   seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_blk <= 1'b0;
            finished <= 1'b0;
            seen     <= 0;
        end else if (start) begin
            open_blk <= 1'b1;
            finished <= 1'b0;
            seen     <= 0;
        end else begin
            if (done) finished <= 1'b1;
            if (open_blk && in_valid) begin
                seen <= seen + 1;
                if (seen == BLOCK_WORDS - 1) open_blk <= 1'b0;
            end
        end
    end

    AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
        start |=> (sad_sum == '0) && !done);                           // R2

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
        !start |=> (sad_sum >= $past(sad_sum)) &&
                   (int'(sad_sum) - int'($past(sad_sum)) <= MAX_STEP)); // R3

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!start && !in_valid) |=> $stable(sad_sum));                   // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                               // R6

    AST_DONE_COUNT: assert property (@(posedge clk) disable iff (rst)
        done |-> (seen == BLOCK_WORDS));                               // R6

    AST_SUM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (finished && !start) |=> $stable(sad_sum));                    // R7
endmodule

bind pkbyte_sad sad_chk #(
    .LANES       (LANES),
    .BLOCK_WORDS (BLOCK_WORDS),
    .ACC_W       (ACC_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .in_valid (in_valid),
    .done     (done),
    .sad_sum  (sad_sum)
);

// File: tb/pkbyte_sad_tb.sv
module pkbyte_sad_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] cur_word = '0;
    logic [31:0] ref_word = '0;
    logic        done;
    logic [13:0] sad_sum;

    int    n_vec  = 0;
    int    n_fail = 0;
    int    cycles = 0;
    string phase  = "R1";

    // behavioural reference state
    int m_sum = 0, m_cnt = 0;
    bit m_run = 0, m_done = 0;

    always #2 clk = ~clk;   // 4 ns period

    pkbyte_sad u_dut (
        .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
        .cur_word(cur_word), .ref_word(ref_word),
        .done(done), .sad_sum(sad_sum)
    );

    function automatic int word_sad(input logic [31:0] c, input logic [31:0] r);
        int s = 0;
        for (int k = 0; k < 4; k++) begin
            int a = int'(c[8*k +: 8]);
            int b = int'(r[8*k +: 8]);
            s += (a > b) ? a - b : b - a;
        end
        return s;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_sum = 0; m_cnt = 0; m_run = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (start) begin
                m_sum = 0; m_cnt = 0; m_run = 1;
            end else if (m_run && in_valid) begin
                m_sum += word_sad(cur_word, ref_word);
                m_cnt++;
                if (m_cnt == 16) begin
                    m_run = 0; m_done = 1;
                end
            end
        end
    end

    // every-cycle comparison away from the active edge
    always @(negedge clk) begin
        n_vec++;
        if (int'(sad_sum) != m_sum || done !== m_done) begin
            n_fail++;
            $display("FAIL %s: sum=%0d done=%0b expected sum=%0d done=%0b",
                     phase, sad_sum, done, m_sum, m_done);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input bit s, input bit v, input logic [31:0] c, input logic [31:0] r);
        @(negedge clk);
        start = s; in_valid = v; cur_word = c; ref_word = r;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 32'h0, 32'h0);
    endtask

    task automatic rand_block(input bit gaps);
        for (int w = 0; w < 16; w++) begin
            if (gaps && (w % 3 == 1)) drive(0, 0, $urandom, $urandom);
            drive(0, 1, $urandom, $urandom);
        end
    endtask

    initial begin
        idle(3);
        @(negedge clk); rst = 1'b0;
        phase = "R1";
        check("R1", int'(sad_sum), 0);
        check("R1", int'(done), 0);

        phase = "R8";
        for (int i = 0; i < 5; i++) drive(0, 1, 32'hFF00FF00, 32'h00FF00FF);
        drive(0, 0, 0, 0);
        @(negedge clk);
        check("R8", int'(sad_sum), 0);

        phase = "R2";
        drive(1, 1, 32'hFFFFFFFF, 32'h00000000);
        drive(0, 0, 0, 0);
        check("R2", int'(sad_sum), 0);

        phase = "R3";
        rand_block(0);
        drive(0, 0, 0, 0);
        check("R6", int'(done), 1);

        phase = "R7";
        for (int i = 0; i < 4; i++) drive(0, 1, $urandom, $urandom);
        drive(0, 0, 0, 0);
        @(negedge clk);
        check("R7", int'(done), 0);

        phase = "R5";
        drive(1, 0, 0, 0);
        rand_block(1);
        idle(3);

        phase = "R4";
        drive(1, 0, 0, 0);
        for (int w = 0; w < 16; w++)
            drive(0, 1, (w % 2) ? 32'h00FF10F0 : 32'h01020304,
                        (w % 2) ? 32'hFF00F010 : 32'h04030201);
        drive(0, 0, 0, 0);
        check("R4", int'(sad_sum), 8 * (255 + 255 + 224 + 224) + 8 * (3 + 1 + 1 + 3));

        phase = "R9";
        drive(1, 0, 0, 0);
        for (int w = 0; w < 16; w++)
            drive(0, 1, (w % 2) ? 32'h00000000 : 32'hFFFFFFFF,
                        (w % 2) ? 32'hFFFFFFFF : 32'h00000000);
        drive(0, 0, 0, 0);
        check("R9", int'(sad_sum), 16320);

        phase = "R10";
        drive(1, 0, 0, 0);
        for (int w = 0; w < 7; w++) drive(0, 1, $urandom, $urandom);
        drive(1, 0, 0, 0);
        rand_block(0);
        idle(2);

        phase = "R1";
        drive(0, 1, 32'h11111111, 32'h22222222);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; in_valid = 1'b0;
        check("R1", int'(sad_sum), 0);
        idle(2);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule